// File: doc/BRIEF.md
# Asynchronous Bytewide SRAM Controller

This block sits between a clocked host and a 128K x 8 asynchronous static RAM. The host issues single-byte read or write requests. The controller turns each request into a timed sequence on the memory's active-low chip-enable, write-enable and output-enable strobes. It presents a 17-bit address and drives an 8-bit data bus that is split into an output value, a tristate enable and an input value, so that the pad cell can be placed outside the block.

All timing is counted in clock cycles set by parameters. These are the address setup before a strobe falls, the read access window, the write pulse width, the delay before the data bus is driven, and the recovery gap. The defaults cover a 70 ns part at a 5 ns clock. During a write, output-enable stays high. Write-enable rises one cycle before chip-enable, and the data drive is released in that same edge. Every access is followed by a recovery gap in which all strobes are high, and the controller accepts no new request until that gap has passed.

Read data is captured at the end of the access window. It is handed back with a one-cycle valid pulse and then held until the next read completes. The host sees a single `ready` signal, which is high only while the controller is idle.

Top module: `bsram_ctrl`

## Requirements
- R1: While reset is asserted and just after it, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rvalid` is 0 and `ready` is 1.
- R2: A read holds `mem_ce_n`=0 and `mem_oe_n`=0 with `mem_we_n`=1 for exactly RD_CYC cycles. The controller samples `mem_dq_i` at the end of that window and returns it on `rdata`. `rvalid` is high for exactly one cycle, and that cycle is the first one after the strobes return high.
- R3: The address is placed on `mem_addr` exactly SETUP_CYC cycles before `mem_ce_n` falls. It does not change while `mem_ce_n` is 0.
- R4: A write holds `mem_ce_n`=0 and `mem_we_n`=0 for exactly WR_CYC cycles. `mem_oe_n` stays 1 throughout, so output-enable and write-enable are never low together.
- R5: In a write, `mem_dq_oe` rises exactly DRV_DLY cycles after `mem_we_n` falls and stays high until `mem_we_n` rises. It is 0 whenever `mem_we_n` or `mem_ce_n` is 1. The byte on `mem_dq_o` at the end of the pulse is the request's write data.
- R6: A write is ended by `mem_we_n` rising. `mem_ce_n` stays 0 for one more cycle, during which `mem_dq_oe` is 0.
- R7: After `mem_ce_n` rises at the end of any access, all strobes stay high. `ready` stays 0 for exactly REC_CYC cycles and then returns to 1.
- R8: A request is accepted only in a cycle where `req` and `ready` are both 1. A request raised while `ready` is 0 is dropped: it creates no memory cycle and does not alter the access in progress.
- R9: `rdata` keeps the last read value through later writes and idle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe from the host |
| req_we | input | 1 | 1 selects a write, 0 a read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data of the request |
| ready | output | 1 | Idle, a request may be issued |
| rvalid | output | 1 | One-cycle pulse, `rdata` updated |
| rdata | output | DATA_W | Last byte read |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Tristate enable for `mem_dq_o` |
| mem_dq_i | input | DATA_W | Data returned by the memory |

## Verification
The hardest case to reach from the ports is a read that samples too early. A design that counts its wait states one short still returns plausible data unless the memory model punishes an early sample. The bench model therefore counts how long the read strobes have been low. It returns the inverted byte until the full access window has elapsed, so any shortened window shows up as wrong data. The other hard case is a request that arrives while the controller is busy. The bench pulses such a request in the setup phase of a write, aimed at another address, and then reads both addresses back.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_READ  = 3'd2,
      ST_WRITE = 3'd3,
      ST_WHOLD = 3'd4,
      ST_RECOV = 3'd5
   } bsram_state_e;

   typedef struct packed {
      logic ce_n;
      logic we_n;
      logic oe_n;
      logic dq_oe;
   } bsram_pins_t;

endpackage

// File: rtl/bsram_timer.sv
module bsram_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/bsram_strobe_dec.sv
module bsram_strobe_dec
   import bsram_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter int DRV_LAST = 0
) (
   input  bsram_state_e     state,
   input  logic [CNT_W-1:0] cnt,
   output bsram_pins_t      pins
);

   localparam logic [CNT_W-1:0] DRV_LAST_V = CNT_W'(DRV_LAST);

   always_comb begin
      pins = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};
      case (state)
         ST_READ: begin
            pins.ce_n = 1'b0;
            pins.oe_n = 1'b0;
         end
         ST_WRITE: begin
            pins.ce_n  = 1'b0;
            pins.we_n  = 1'b0;
            pins.dq_oe = (cnt <= DRV_LAST_V);
         end
         ST_WHOLD: pins.ce_n = 1'b0;
         default: ;
      endcase
   end

endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
   import bsram_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int SETUP_CYC = 1,
   parameter int RD_CYC    = 14,
   parameter int WR_CYC    = 12,
   parameter int DRV_DLY   = 5,
   parameter int REC_CYC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output logic              rvalid,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int MAX_CYC  = (RD_CYC > WR_CYC) ?
                             ((RD_CYC > SETUP_CYC) ? ((RD_CYC > REC_CYC) ? RD_CYC : REC_CYC)
                                                   : ((SETUP_CYC > REC_CYC) ? SETUP_CYC : REC_CYC))
                           : ((WR_CYC > SETUP_CYC) ? ((WR_CYC > REC_CYC) ? WR_CYC : REC_CYC)
                                                   : ((SETUP_CYC > REC_CYC) ? SETUP_CYC : REC_CYC));
   localparam int CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
   localparam int DRV_LAST = WR_CYC - 1 - DRV_DLY;

   localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LD    = CNT_W'(WR_CYC - 1);
   localparam logic [CNT_W-1:0] REC_LD   = CNT_W'(REC_CYC - 1);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("bsram_ctrl: bus widths must be positive");
      end
      if (SETUP_CYC < 1 || RD_CYC < 1 || WR_CYC < 1 || REC_CYC < 1) begin : g_bad_cyc
         $error("bsram_ctrl: every phase needs at least one cycle");
      end
      if (DRV_DLY < 0 || DRV_DLY >= WR_CYC) begin : g_bad_drv
         $error("bsram_ctrl: drive delay must end inside the write pulse");
      end
   endgenerate

   bsram_state_e      state;
   logic              op_we;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic [CNT_W-1:0]  tmr_cnt;
   logic              tmr_done;
   bsram_pins_t       pins;

   bsram_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .cnt      (tmr_cnt),
      .done     (tmr_done)
   );

   bsram_strobe_dec #(.CNT_W(CNT_W), .DRV_LAST(DRV_LAST)) u_dec (
      .state (state),
      .cnt   (tmr_cnt),
      .pins  (pins)
   );

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state)
         ST_IDLE: begin
            tmr_load = req;
            tmr_val  = SETUP_LD;
         end
         ST_SETUP: begin
            tmr_load = tmr_done;
            tmr_val  = op_we ? WR_LD : RD_LD;
         end
         ST_READ: begin
            tmr_load = tmr_done;
            tmr_val  = REC_LD;
         end
         ST_WHOLD: begin
            tmr_load = 1'b1;
            tmr_val  = REC_LD;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         op_we    <= 1'b0;
         mem_addr <= '0;
         mem_dq_o <= '0;
         rdata    <= '0;
         rvalid   <= 1'b0;
      end else begin
         rvalid <= 1'b0;
         case (state)
            ST_IDLE: if (req) begin
               state    <= ST_SETUP;
               op_we    <= req_we;
               mem_addr <= req_addr;
               if (req_we) mem_dq_o <= req_wdata;
            end
            ST_SETUP: if (tmr_done) state <= op_we ? ST_WRITE : ST_READ;
            ST_READ: if (tmr_done) begin
               rdata  <= mem_dq_i;
               rvalid <= 1'b1;
               state  <= ST_RECOV;
            end
            ST_WRITE: if (tmr_done) state <= ST_WHOLD;
            ST_WHOLD: state <= ST_RECOV;
            ST_RECOV: if (tmr_done) state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign ready     = (state == ST_IDLE);
   assign mem_ce_n  = pins.ce_n;
   assign mem_we_n  = pins.we_n;
   assign mem_oe_n  = pins.oe_n;
   assign mem_dq_oe = pins.dq_oe;

   // R4
   no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   // R5
   drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_ce_n && !mem_we_n && mem_oe_n));

   // R6
   we_ends_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (!mem_ce_n && !mem_dq_oe));

   // R3
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

   // R2
   rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !rvalid);

   // R8
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req) |=> !ready);

   // R7
   recov_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_ce_n) |-> (!ready && mem_we_n && mem_oe_n));

endmodule

// File: tb/bsram_ctrl_tb.sv
module bsram_ctrl_tb;

   localparam int ADDR_W = 6;
   localparam int DATA_W = 8;
   localparam int SET    = 2;
   localparam int RD     = 14;
   localparam int WR     = 10;
   localparam int DRV    = 3;
   localparam int REC    = 3;
   localparam int NWORDS = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req = 1'b0;
   logic              req_we = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              ready, rvalid;
   logic [DATA_W-1:0] rdata;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [DATA_W-1:0] mem_dq_o, mem_dq_i;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   bsram_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SET), .RD_CYC(RD),
      .WR_CYC(WR), .DRV_DLY(DRV), .REC_CYC(REC)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
      .rvalid(rvalid), .rdata(rdata), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] pat(input int a, input int s);
      logic [7:0] v;
      v = 8'((a * 29 + 7 + s * 101) & 255);
      return s[0] ? ~v : v;
   endfunction

   // memory model: data is valid only after RD full cycles of read strobes
   logic [7:0] mem [NWORDS];
   int         acc = 0;
   assign mem_dq_i = (acc >= RD) ? mem[mem_addr] : ~mem[mem_addr];

   bit p_ce = 1, p_we = 1, p_ready = 1;
   int setup_cnt = 0, wr_run = 0, rd_run = 0, drv_wait = 0, rec_cnt = 0;
   bit seen_drv = 0, moved = 0, oe_bad = 0, in_rec = 0;
   logic [ADDR_W-1:0] start_addr = '0;
   logic [7:0]        wdat = '0;

   always @(negedge clk) begin
      if (!rst_n) begin
         acc = 0;
         p_ce = 1; p_we = 1; p_ready = 1; in_rec = 0;
      end else begin
         if (!mem_ce_n && !mem_oe_n && mem_we_n) acc = acc + 1; else acc = 0;
         if (p_ready && !ready) setup_cnt = 0;
         if (!ready && mem_ce_n && !in_rec && p_ce) setup_cnt++;
         if (p_ce && !mem_ce_n) begin
            // R3 setup
            chk(setup_cnt == SET, "R3 setup", setup_cnt, SET);
            wr_run = 0; rd_run = 0; drv_wait = 0; seen_drv = 0;
            moved = 0; oe_bad = 0; start_addr = mem_addr;
         end
         if (!mem_ce_n) begin
            if (mem_addr != start_addr) moved = 1;
            if (!mem_we_n) begin
               wr_run++;
               if (!mem_oe_n) oe_bad = 1;
               if (mem_dq_oe) begin seen_drv = 1; wdat = mem_dq_o; end
               else if (!seen_drv) drv_wait++;
            end
            if (!mem_oe_n) rd_run++;
         end
         if (!p_we && mem_we_n) begin
            chk(wr_run == WR, "R4 pulse", wr_run, WR);
            chk(!oe_bad, "R4 oe high", int'(oe_bad), 0);
            chk(drv_wait == DRV && seen_drv, "R5 drive delay", drv_wait, DRV);
            chk(!mem_ce_n && !mem_dq_oe, "R6 ce hold", int'(mem_ce_n), 0);
            mem[mem_addr] = wdat;
         end
         if (!p_ce && mem_ce_n) begin
            chk(!moved, "R3 addr hold", int'(moved), 0);
            chk(!mem_dq_oe, "R5 released", int'(mem_dq_oe), 0);
            if (rd_run > 0) begin
               chk(rd_run == RD, "R2 window", rd_run, RD);
               chk(rvalid === 1'b1, "R2 rvalid timing", int'(rvalid), 1);
            end
            in_rec = 1; rec_cnt = 0;
         end
         if (in_rec) begin
            if (!ready) rec_cnt++;
            else begin
               chk(rec_cnt == REC, "R7 recovery", rec_cnt, REC);
               in_rec = 0;
            end
         end
         p_ce = mem_ce_n; p_we = mem_we_n; p_ready = ready;
      end
   end

   task automatic issue(input bit we, input int a, input logic [7:0] d);
      while (!ready) @(negedge clk);
      req = 1'b1; req_we = we; req_addr = ADDR_W'(a); req_wdata = d;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic do_read(input int a, input logic [7:0] exp, input string rq);
      issue(1'b0, a, 8'h00);
      while (!rvalid) @(negedge clk);
      chk(rdata == exp, rq, int'(rdata), int'(exp));
      @(negedge clk);
      chk(!rvalid, "R2 pulse width", int'(rvalid), 0);
   endtask

   task automatic finish_run;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      for (int i = 0; i < NWORDS; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes", int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
      chk(!mem_dq_oe && !rvalid, "R1 drive/rvalid", int'({mem_dq_oe, rvalid}), 0);
      chk(ready, "R1 ready", int'(ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ready && mem_ce_n && !mem_dq_oe, "R1 after release", int'(ready), 1);

      for (int a = 0; a < NWORDS; a++) issue(1'b1, a, pat(a, 0));
      for (int a = 0; a < NWORDS; a++) do_read(a, pat(a, 0), "R2 data pass0");
      for (int a = NWORDS - 1; a >= 0; a--) issue(1'b1, a, pat(a, 1));
      for (int a = 0; a < NWORDS; a += 3) do_read(a, pat(a, 1), "R2 data pass1");

      // R8: request during a busy write is dropped
      issue(1'b1, 5, 8'h3C);
      chk(!ready, "R8 busy", int'(ready), 0);
      req = 1'b1; req_we = 1'b1; req_addr = ADDR_W'(6); req_wdata = 8'hEE;
      @(negedge clk);
      req = 1'b0;
      do_read(6, pat(6, 1), "R8 dropped request");
      do_read(5, 8'h3C, "R8 current write intact");

      // R9: rdata held over writes and idle
      do_read(9, pat(9, 1), "R2 data");
      issue(1'b1, 10, 8'h81);
      repeat (40) @(negedge clk);
      chk(rdata == pat(9, 1), "R9 rdata held", int'(rdata), int'(pat(9, 1)));
      do_read(10, 8'h81, "R5 write data");

      repeat (10) @(negedge clk);
      finish_run();
   end

endmodule